// File: doc/BRIEF.md
# TDM Channel-Windowed PRBS Tester

This block runs a bit-error-rate test on one serial TDM stream pair. The stream runs one bit per clock. There are 32 channels of 8 bits each, so a frame is 256 bit slots. A frame pulse marks bit 0 of channel 0.

The block selects a window of channels by a start channel and a length. On the transmit side, inside that window, the normal output bit is replaced by a 2^15-1 pseudorandom sequence. Every bit outside the window passes through unchanged.

On the receive side the same window is compared against a locally regenerated copy of the sequence. The checker locks onto whatever phase of the sequence arrives. After it has locked, it counts each wrong bit in a saturating error counter.

The generator and the checker have independent enable inputs. This lets a test patch the pattern into a live stream and check a looped-back or remote copy. Such a test can cover a single channel, a full frame, or any run of channels in between.

Top module: `tdm_prbs_tester`

## Requirements
- R1: The generator is a 15-bit shift register using x^15 + x^14 + 1, seeded to all ones by reset. Each emitted bit is the register's top bit, so the sequence obeys b[k+15] = b[k] xor b[k+1]. The first 16 bits emitted after reset are fifteen ones followed by a zero.
- R2: A high `frame_pulse` marks slot 0 of a frame and realigns the slot count even in the middle of a frame. The slot count then runs 0..255. The channel number is the slot number divided by 8.
- R3: The window covers channels `win_start` through `win_start + win_len_m1`, inclusive. A window that would run past channel 31 stops at the end of the frame.
- R4: When `tx_en` is low or the slot lies outside the window, `tx_bit` equals `tx_data_in` in the same cycle, and the generator state does not move.
- R5: When `tx_en` is high and the slot lies inside the window, `tx_bit` carries the next sequence bit in the same cycle. The generator advances by one step on each such bit only.
- R6: While `rst_n` is low, `err_count` reads 0, `rx_sync` reads 0, and `tx_bit` follows `tx_data_in` regardless of the enables.
- R7: With `rx_en` high, the checker takes its state from the first 15 received window bits. `rx_sync` is 0 after 14 such bits and reads 1 after the 15th.
- R8: After sync, each window bit that differs from the predicted sequence bit raises `err_count` by exactly one. The prediction continues from the checker's own state, so one flipped bit counts once. Received bits outside the window have no effect.
- R9: `err_count` is 16 bits wide and stays at 65535 once it reaches it.
- R10: Lowering `rx_en` clears `rx_sync` and restarts loading but keeps `err_count`. A rising edge of `rx_en` clears `err_count`.
- R11: Asserting `rst_n` clears the error count and sync at once and reseeds the generator. Release is synchronized over two clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one stream bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | High in the cycle of slot 0 |
| rx_bit | input | 1 | Received serial bit |
| tx_data_in | input | 1 | Normal outgoing data bit |
| win_start | input | 5 | First channel of the window |
| win_len_m1 | input | 5 | Window length in channels, minus one |
| tx_en | input | 1 | Generator enable |
| rx_en | input | 1 | Checker enable |
| tx_bit | output | 1 | Outgoing serial bit after insertion |
| err_count | output | 16 | Saturating bit-error count |
| rx_sync | output | 1 | Checker has loaded and is comparing |

## Verification
The hardest state to reach from the ports is a saturated error counter. Reaching it needs more than 65535 wrong bits, all arriving after the checker has locked. The bench gets there by opening a full-frame window and letting the first 15 bits through unharmed. It then inverts every later bit against its own model of the sequence for about 260 frames. Along the way it checks the running count arithmetically against the number of window bits sent.

The sync boundary is also probed. The bench samples `rx_sync` exactly after the 14th and the 15th window bit, using a narrow window that spans frames.

// File: rtl/tdm_prbs_pkg.sv
package tdm_prbs_pkg;

  localparam int PRBS_W = 15;

  typedef logic [PRBS_W-1:0] prbs_t;

  // one step of x^15 + x^14 + 1, emitted bit is the top bit
  function automatic prbs_t prbs_step(input prbs_t s);
    return {s[PRBS_W-2:0], s[PRBS_W-1] ^ s[PRBS_W-2]};
  endfunction

  // predicted next bit from the last 15 bits (top = oldest)
  function automatic logic prbs_predict(input prbs_t s);
    return s[PRBS_W-1] ^ s[PRBS_W-2];
  endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int CH_BITS = 8,
  parameter int NUM_CH  = 32,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_pulse,
  input  logic [CH_W-1:0] win_start,
  input  logic [CH_W-1:0] win_len_m1,
  output logic            in_win
);

  localparam int SLOTS  = CH_BITS * NUM_CH;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BIT_W  = $clog2(CH_BITS);

  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_d;
  logic [CH_W-1:0]   cur_ch;
  logic [CH_W:0]     win_last;

  always_comb begin
    if (frame_pulse) begin
      slot_d = '0;
    end else if (slot_q == SLOT_W'(SLOTS - 1)) begin
      slot_d = '0;
    end else begin
      slot_d = slot_q + 1'b1;
    end
  end

  assign cur_ch   = slot_d[SLOT_W-1:BIT_W];
  assign win_last = {1'b0, win_start} + {1'b0, win_len_m1};
  assign in_win   = ({1'b0, cur_ch} >= {1'b0, win_start}) &&
                    ({1'b0, cur_ch} <= win_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SLOT_W'(SLOTS - 1);
    end else begin
      slot_q <= slot_d;
    end
  end

endmodule

// File: rtl/tdm_prbs_gen.sv
module tdm_prbs_gen
  import tdm_prbs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  output prbs_t state
);

  prbs_t state_q;
  prbs_t state_d;

  always_comb begin
    state_d = state_q;
    if (adv) begin
      state_d = prbs_step(state_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '1;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/tdm_prbs_chk.sv
module tdm_prbs_chk
  import tdm_prbs_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             win,
  input  logic             rx_bit,
  output logic             sync,
  output logic [ERR_W-1:0] err_count
);

  localparam int FILL_W = $clog2(PRBS_W + 1);

  logic              en_q;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              sync_q, sync_d;
  prbs_t             hist_q, hist_d;
  logic [ERR_W-1:0]  err_q, err_d;
  logic              en_rise;
  logic              pred;

  assign en_rise = en && !en_q;
  assign pred    = prbs_predict(hist_q);

  always_comb begin
    fill_d = fill_q;
    sync_d = sync_q;
    hist_d = hist_q;
    err_d  = err_q;
    if (!en) begin
      fill_d = '0;
      sync_d = 1'b0;
    end else begin
      if (en_rise) begin
        err_d = '0;
      end
      if (win) begin
        if (!sync_q) begin
          hist_d = {hist_q[PRBS_W-2:0], rx_bit};
          fill_d = fill_q + 1'b1;
          if (fill_q == FILL_W'(PRBS_W - 1)) begin
            sync_d = 1'b1;
          end
        end else begin
          hist_d = {hist_q[PRBS_W-2:0], pred};
          if ((rx_bit != pred) && (err_q != '1)) begin
            err_d = err_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      fill_q <= '0;
      sync_q <= 1'b0;
      hist_q <= '0;
      err_q  <= '0;
    end else begin
      en_q   <= en;
      fill_q <= fill_d;
      sync_q <= sync_d;
      hist_q <= hist_d;
      err_q  <= err_d;
    end
  end

  assign sync      = sync_q;
  assign err_count = err_q;

endmodule

// File: rtl/tdm_prbs_tester.sv
module tdm_prbs_tester
  import tdm_prbs_pkg::*;
#(
  parameter int CH_BITS = 8,
  parameter int NUM_CH  = 32,
  parameter int ERR_W   = 16,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_pulse,
  input  logic             rx_bit,
  input  logic             tx_data_in,
  input  logic [CH_W-1:0]  win_start,
  input  logic [CH_W-1:0]  win_len_m1,
  input  logic             tx_en,
  input  logic             rx_en,
  output logic             tx_bit,
  output logic [ERR_W-1:0] err_count,
  output logic             rx_sync
);

  logic  rst_meta_q;
  logic  rst_sync_n;
  logic  in_win;
  logic  tx_active;
  prbs_t gen_state;

  // asynchronous assertion, two-flop synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  tdm_slot_timer #(
    .CH_BITS (CH_BITS),
    .NUM_CH  (NUM_CH)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_pulse (frame_pulse),
    .win_start   (win_start),
    .win_len_m1  (win_len_m1),
    .in_win      (in_win)
  );

  assign tx_active = tx_en && in_win && rst_sync_n;

  tdm_prbs_gen u_gen (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv   (tx_active),
    .state (gen_state)
  );

  assign tx_bit = tx_active ? gen_state[PRBS_W-1] : tx_data_in;

  tdm_prbs_chk #(
    .ERR_W (ERR_W)
  ) u_chk (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (rx_en),
    .win       (in_win),
    .rx_bit    (rx_bit),
    .sync      (rx_sync),
    .err_count (err_count)
  );

endmodule

// File: rtl/tdm_prbs_tester_chk.sv
module tdm_prbs_tester_chk
  import tdm_prbs_pkg::*;
#(
  parameter int ERR_W = 16,
  parameter int CH_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_pulse,
  input logic [CH_W-1:0]  win_start,
  input logic             tx_en,
  input logic             rx_en,
  input logic             in_win,
  input prbs_t            gen_state,
  input logic [ERR_W-1:0] err_count,
  input logic             rx_sync
);

  // R1
  gen_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_state != '0);

  // R2
  frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse && (win_start == '0)) |-> in_win);

  // R4
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en && in_win) |=> $stable(gen_state));

  // R8
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != $past(err_count)) |->
      ((err_count == ERR_W'($past(err_count) + 1'b1)) || (err_count == '0)));

  // R9
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_count == '1) && rx_en && $past(rx_en)) |=> (err_count == '1));

  // R7
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_sync) |-> ($past(rx_en) && $past(in_win)));

  // R10
  sync_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sync |-> $past(rx_en));

endmodule

bind tdm_prbs_tester tdm_prbs_tester_chk #(
  .ERR_W (ERR_W),
  .CH_W  (CH_W)
) u_prop (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .frame_pulse (frame_pulse),
  .win_start   (win_start),
  .tx_en       (tx_en),
  .rx_en       (rx_en),
  .in_win      (in_win),
  .gen_state   (gen_state),
  .err_count   (err_count),
  .rx_sync     (rx_sync)
);

// File: tb/tdm_prbs_tester_tb.sv
module tdm_prbs_tester_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_pulse;
  logic        rx_bit;
  logic        tx_data_in;
  logic [4:0]  win_start;
  logic [4:0]  win_len_m1;
  logic        tx_en;
  logic        rx_en;
  logic        tx_bit;
  logic [15:0] err_count;
  logic        rx_sync;

  int checks   = 0;
  int failures = 0;

  // bench models
  int          s;
  int          fr;
  logic [14:0] gen_m;
  logic [14:0] rx_m;
  int          rx_idx;
  bit          chk_tx;
  bit          sync_chk;
  bit          inj_set;
  bit          inj_all;
  logic [15:0] cap;
  int          cap_n;

  always #4 clk = ~clk;

  tdm_prbs_tester u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_pulse (frame_pulse),
    .rx_bit      (rx_bit),
    .tx_data_in  (tx_data_in),
    .win_start   (win_start),
    .win_len_m1  (win_len_m1),
    .tx_en       (tx_en),
    .rx_en       (rx_en),
    .tx_bit      (tx_bit),
    .err_count   (err_count),
    .rx_sync     (rx_sync)
  );

  function automatic logic [14:0] step(input logic [14:0] v);
    return {v[13:0], v[14] ^ v[13]};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bit slot; entered and left just after a falling edge
  task automatic cyc();
    bit   w;
    bit   flip;
    int   ch;
    logic exp;
    ch = s / 8;
    w  = (ch >= int'(win_start)) && (ch <= int'(win_start) + int'(win_len_m1));
    frame_pulse = (s == 0);
    tx_data_in  = s[0] ^ s[3] ^ fr[0];
    flip = (inj_all && rx_idx >= 15) ||
           (inj_set && (rx_idx == 40 || rx_idx == 77 || rx_idx == 100));
    rx_bit = w ? (rx_m[14] ^ flip) : s[1];
    #1;
    if (chk_tx) begin
      if (tx_en && w) begin
        exp = gen_m[14];
        check(tx_bit == exp, "R5 R3 window bit", tx_bit, exp);
      end else begin
        exp = tx_data_in;
        check(tx_bit == exp, "R4 R3 passthrough bit", tx_bit, exp);
      end
    end
    if (tx_en && w && cap_n < 16) begin
      cap = {cap[14:0], tx_bit};
      cap_n++;
    end
    if (tx_en && w) gen_m = step(gen_m);
    if (w) rx_m = step(rx_m);
    @(posedge clk);
    @(negedge clk);
    if (rx_en && w) begin
      rx_idx++;
      if (sync_chk && rx_idx == 14) check(rx_sync == 1'b0, "R7 no sync after 14", rx_sync, 0);
      if (sync_chk && rx_idx == 15) check(rx_sync == 1'b1, "R7 sync after 15", rx_sync, 1);
    end
    s = s + 1;
    if (s == 256) begin
      s = 0;
      fr++;
    end
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n * 256; i++) cyc();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    s = 0;
    gen_m = '1;
    cap = '0;
    cap_n = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    frame_pulse = 1'b0;
    rx_bit = 1'b0;
    tx_data_in = 1'b0;
    win_start = 5'd0;
    win_len_m1 = 5'd31;
    tx_en = 1'b1;
    rx_en = 1'b0;
    s = 0; fr = 0; rx_idx = 0;
    chk_tx = 1'b0; sync_chk = 1'b0; inj_set = 1'b0; inj_all = 1'b0;
    gen_m = '1; rx_m = 15'h2A5F; cap = '0; cap_n = 0;

    // R6: held in reset with generator enabled
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      tx_data_in = i[0];
      #1;
      check(tx_bit == tx_data_in, "R6 passthrough in reset", tx_bit, tx_data_in);
      @(negedge clk);
    end
    check(err_count == 16'd0, "R6 err in reset", err_count, 0);
    check(rx_sync == 1'b0, "R6 sync in reset", rx_sync, 0);
    tx_en = 1'b0;
    do_reset();

    // R1, R5: first bits after reset on a full window
    tx_en = 1'b1;
    chk_tx = 1'b1;
    frames(1);
    check(cap == 16'hFFFE, "R1 first 16 bits", cap, 16'hFFFE);

    // R3: window sweep, including truncation at frame end
    win_start = 5'd5;  win_len_m1 = 5'd3;  frames(2);
    win_start = 5'd30; win_len_m1 = 5'd5;  frames(2);
    win_start = 5'd31; win_len_m1 = 5'd0;  frames(1);
    win_start = 5'd12; win_len_m1 = 5'd0;  frames(1);
    win_start = 5'd0;  win_len_m1 = 5'd0;  frames(1);
    win_start = 5'd7;  win_len_m1 = 5'd20; frames(2);

    // R4: generator disabled, state must hold for later bits
    tx_en = 1'b0;
    frames(1);
    tx_en = 1'b1;
    frames(1);

    // R2: early frame pulse realigns mid-frame
    for (int i = 0; i < 100; i++) cyc();
    s = 0;
    frames(2);

    // R7, R8: checker on window 3..6 (32 bits per frame)
    tx_en = 1'b0;
    win_start = 5'd3; win_len_m1 = 5'd3;
    rx_m = 15'h2A5F;
    rx_idx = 0;
    rx_en = 1'b1;
    sync_chk = 1'b1;
    inj_set = 1'b1;
    frames(1);
    check(err_count == 16'd0, "R8 no errors before injection", err_count, 0);
    frames(3);
    check(rx_sync == 1'b1, "R7 sync held", rx_sync, 1);
    check(err_count == 16'd3, "R8 three single errors", err_count, 3);
    inj_set = 1'b0;

    // R10: disable keeps count, clears sync; rising edge clears count
    rx_en = 1'b0;
    frames(1);
    check(err_count == 16'd3, "R10 count kept while disabled", err_count, 3);
    check(rx_sync == 1'b0, "R10 sync cleared", rx_sync, 0);
    rx_en = 1'b1;
    rx_idx = 0;
    cyc();
    check(err_count == 16'd0, "R10 count cleared on enable", err_count, 0);
    for (int i = 0; i < 255; i++) cyc();
    check(rx_sync == 1'b1, "R7 resync", rx_sync, 1);

    // R9: saturation with full window, every bit after sync wrong
    rx_en = 1'b0;
    frames(1);
    win_start = 5'd0; win_len_m1 = 5'd31;
    rx_en = 1'b1;
    rx_idx = 0;
    inj_all = 1'b1;
    frames(100);
    check(err_count == 16'd25585, "R8 running count", err_count, 25585);
    frames(160);
    check(err_count == 16'hFFFF, "R9 saturated", err_count, 16'hFFFF);
    frames(1);
    check(err_count == 16'hFFFF, "R9 stays saturated", err_count, 16'hFFFF);
    inj_all = 1'b0;

    // R11: asynchronous reset mid-run, generator reseeded
    rst_n = 1'b0;
    #1;
    check(err_count == 16'd0, "R11 err cleared at once", err_count, 0);
    check(rx_sync == 1'b0, "R11 sync cleared at once", rx_sync, 0);
    rx_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(err_count == 16'd0, "R11 held during release", err_count, 0);
    @(negedge clk);
    repeat (3) @(negedge clk);
    s = 0;
    gen_m = '1;
    cap = '0;
    cap_n = 0;
    tx_en = 1'b1;
    frames(1);
    check(cap == 16'hFFFE, "R11 R1 reseeded", cap, 16'hFFFE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule